// File: doc/BRIEF.md
# Overlapping 2x2 Cluster Finder and Filter

This block turns one region's grid of tower energies into a sparse set of energy clusters. The grid it receives includes a one-tower ring copied from the neighbouring regions. Each tower below a programmable tower threshold counts as zero. The block then sums a 2x2 cluster anchored at every tower position. Because the clusters overlap, every tower sits in up to four of them. A filter keeps a cluster only when it beats all eight clusters that share a tower with it. A surviving cluster is then dropped if its sum is below a programmable cluster threshold.

The whole grid is handled in parallel through three register stages. Towers are indexed row-major: tower (r,c) uses bit slice `(r*TC+c)*EW`. Interior output (i,j) corresponds to the cluster anchored at tower (i+1,j+1), which covers towers (i+1..i+2, j+1..j+2), and uses index `i*(TC-3)+j`. Clusters anchored in the border ring are used only as comparison partners and are never reported.

Top module: `cluster_filter2x2`

## Requirements
- R1: A tower whose energy is strictly below `tower_thr` contributes zero to every sum. A tower equal to or above `tower_thr` contributes its full value.
- R2: A cluster's energy is the sum of its four thresholded towers, carried in EW+2 bits so that four full-scale towers (4 x 511 = 2044) never wrap.
- R3: A cluster survives the filter only when three conditions hold. Its sum must be strictly greater than the clusters anchored up, left, up-left and up-right. It must be greater than or equal to the clusters anchored down, right, down-right and down-left. It must also be non-zero.
- R4: When two overlapping clusters have equal sums, at most one of them is flagged. Of two adjacent survivors, none can share a tower.
- R5: A cluster that passes the filter but whose sum is strictly below `clus_thr` is not flagged. A sum equal to `clus_thr` is kept.
- R6: `clus_e` carries the cluster sum at flagged positions and zero at every other position.
- R7: `clus_veto` for each output is the OR of the raw veto bits of its four towers. It is independent of both thresholds and of the hit flag.
- R8: Inputs present at a rising clock edge appear on the outputs after the third rising edge, counting that one. After only two edges, the outputs still show the previous result.
- R9: While `rst_n` is low, all outputs are zero, and asserting it clears them without waiting for a clock.
- R10: Border-anchored clusters produce no output. A border cluster that is larger still suppresses an interior cluster it overlaps, so a lone tower at interior corner position (1,1) yields no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tower_e | input | TR*TC*EW | Tower energies, row-major, border ring included |
| tower_veto | input | TR*TC | Per-tower veto bits, row-major |
| tower_thr | input | EW | Tower zeroing threshold |
| clus_thr | input | EW+2 | Cluster pruning threshold |
| clus_hit | output | (TR-3)*(TC-3) | Surviving-cluster flags for interior positions |
| clus_e | output | (TR-3)*(TC-3)*(EW+2) | Cluster energy, zero where not flagged |
| clus_veto | output | (TR-3)*(TC-3) | OR of the four tower vetoes of each interior cluster |

## Verification
All three output fields are due together, after the third rising edge that follows an input change. The first stage thresholds the towers, the second forms the sums and the veto ORs, and the third applies the filter and the prune. The bench changes inputs on a falling edge and holds them. It waits three rising edges and samples on the next falling edge. The latency test instead samples after two edges, where the earlier result must still be present, and again one edge later.

// File: rtl/cluster_filter2x2.sv
module cluster_filter2x2 #(
  parameter int TR = 6,
  parameter int TC = 6,
  parameter int EW = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [TR*TC*EW-1:0]               tower_e,
  input  logic [TR*TC-1:0]                  tower_veto,
  input  logic [EW-1:0]                     tower_thr,
  input  logic [EW+1:0]                     clus_thr,
  output logic [(TR-3)*(TC-3)-1:0]          clus_hit,
  output logic [(TR-3)*(TC-3)*(EW+2)-1:0]   clus_e,
  output logic [(TR-3)*(TC-3)-1:0]          clus_veto
);
  localparam int SW = EW + 2;
  localparam int AR = TR - 1;
  localparam int AC = TC - 1;
  localparam int OR = TR - 3;
  localparam int OC = TC - 3;
  localparam int NT = TR * TC;
  localparam int NA = AR * AC;
  localparam int NO = OR * OC;

  logic [NT*EW-1:0] t_d, t_q;
  logic [NT-1:0]    tv_q;
  logic [NA*SW-1:0] s_d, s_q;
  logic [NA-1:0]    sv_d, sv_q;
  logic [NO-1:0]    hit_d;
  logic [NO*SW-1:0] e_d;
  logic [NO-1:0]    v_d;

  function automatic logic [SW-1:0] tw(input logic [NT*EW-1:0] v, input int r, input int c);
    return SW'(v[(r*TC+c)*EW +: EW]);
  endfunction

  function automatic logic [SW-1:0] cl(input logic [NA*SW-1:0] v, input int r, input int c);
    return v[(r*AC+c)*SW +: SW];
  endfunction

  always_comb begin
    for (int k = 0; k < NT; k++)
      t_d[k*EW +: EW] = (tower_e[k*EW +: EW] >= tower_thr) ? tower_e[k*EW +: EW] : '0;
  end

  always_comb begin
    for (int r = 0; r < AR; r++)
      for (int c = 0; c < AC; c++) begin
        s_d[(r*AC+c)*SW +: SW] = tw(t_q, r, c) + tw(t_q, r, c+1)
                               + tw(t_q, r+1, c) + tw(t_q, r+1, c+1);
        sv_d[r*AC+c] = tv_q[r*TC+c] | tv_q[r*TC+c+1]
                     | tv_q[(r+1)*TC+c] | tv_q[(r+1)*TC+c+1];
      end
  end

  always_comb begin
    logic [SW-1:0] x;
    logic          win;
    for (int i = 0; i < OR; i++)
      for (int j = 0; j < OC; j++) begin
        x   = cl(s_q, i+1, j+1);
        win = (x >  cl(s_q, i,   j+1)) && (x >  cl(s_q, i+1, j))
           && (x >  cl(s_q, i,   j))   && (x >  cl(s_q, i,   j+2))
           && (x >= cl(s_q, i+2, j+1)) && (x >= cl(s_q, i+1, j+2))
           && (x >= cl(s_q, i+2, j+2)) && (x >= cl(s_q, i+2, j));
        hit_d[i*OC+j]          = win && (x >= clus_thr);
        e_d[(i*OC+j)*SW +: SW] = hit_d[i*OC+j] ? x : '0;
        v_d[i*OC+j]            = sv_q[(i+1)*AC+j+1];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0; tv_q <= '0;
      s_q <= '0; sv_q <= '0;
      clus_hit <= '0; clus_e <= '0; clus_veto <= '0;
    end else begin
      t_q <= t_d; tv_q <= tower_veto;
      s_q <= s_d; sv_q <= sv_d;
      clus_hit <= hit_d; clus_e <= e_d; clus_veto <= v_d;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  for (genvar i = 0; i < OR; i++) begin : g_ri
    for (genvar j = 0; j < OC; j++) begin : g_ci
      localparam int K = i*OC + j;
      localparam int A = (i+1)*TC + (j+1);

      // R7
      veto_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> clus_veto[K] == ($past(tower_veto[A], 3) | $past(tower_veto[A+1], 3)
                                          | $past(tower_veto[A+TC], 3) | $past(tower_veto[A+TC+1], 3)));
      // R5
      prune_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clus_hit[K] |-> clus_e[K*SW +: SW] >= $past(clus_thr));
      // R3
      hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clus_hit[K] |-> clus_e[K*SW +: SW] != '0);

      if (j < OC-1) begin : g_h
        // R4
        no_pair_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !(clus_hit[K] && clus_hit[K+1]));
      end
      if (i < OR-1) begin : g_v
        // R4
        no_pair_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !(clus_hit[K] && clus_hit[K+OC]));
        if (j < OC-1) begin : g_d
          // R4
          no_pair_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(clus_hit[K] && clus_hit[K+OC+1]));
        end
        if (j > 0) begin : g_a
          // R4
          no_pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(clus_hit[K] && clus_hit[K+OC-1]));
        end
      end
    end
  end
endmodule

// File: tb/sim_cluster_filter2x2.sv
module sim_cluster_filter2x2;
  localparam int TR = 6, TC = 6, EW = 9;
  localparam int SW = EW + 2, OR = TR - 3, OC = TC - 3, NO = OR * OC;

  typedef struct packed {
    logic [15:0] seed;
    logic [8:0]  tthr;
    logic [10:0] cthr;
    logic [8:0]  emask;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{16'hACE1, 9'd0,   11'd0,   9'h1FF},
    '{16'h1234, 9'd100, 11'd0,   9'h1FF},
    '{16'hBEEF, 9'd0,   11'd600, 9'h1FF},
    '{16'h0F0F, 9'd0,   11'd0,   9'h007},
    '{16'h5555, 9'd3,   11'd5,   9'h003},
    '{16'hC0DE, 9'd200, 11'd900, 9'h1FF}
  };

  logic clk = 0, rst_n = 0;
  logic [TR*TC*EW-1:0] tower_e = '0;
  logic [TR*TC-1:0]    tower_veto = '0;
  logic [EW-1:0]       tower_thr = '0;
  logic [SW-1:0]       clus_thr = '0;
  logic [NO-1:0]       clus_hit, clus_veto;
  logic [NO*SW-1:0]    clus_e;

  int checks = 0, failures = 0;
  int te [TR][TC];
  bit tv [TR][TC];
  logic [NO-1:0]    exp_hit, exp_v;
  logic [NO*SW-1:0] exp_e;

  always #5 clk = ~clk;

  cluster_filter2x2 #(.TR(TR), .TC(TC), .EW(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .tower_e(tower_e), .tower_veto(tower_veto),
    .tower_thr(tower_thr), .clus_thr(clus_thr),
    .clus_hit(clus_hit), .clus_e(clus_e), .clus_veto(clus_veto));

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_grid();
    for (int r = 0; r < TR; r++)
      for (int c = 0; c < TC; c++) begin te[r][c] = 0; tv[r][c] = 0; end
  endtask

  task automatic drive();
    for (int r = 0; r < TR; r++)
      for (int c = 0; c < TC; c++) begin
        tower_e[(r*TC+c)*EW +: EW] = EW'(te[r][c]);
        tower_veto[r*TC+c] = tv[r][c];
      end
  endtask

  task automatic model();
    int tt [TR][TC];
    int cs [TR-1][TC-1];
    int s, r, c, k;
    bit win;
    for (int a = 0; a < TR; a++)
      for (int b = 0; b < TC; b++)
        tt[a][b] = (te[a][b] >= int'(tower_thr)) ? te[a][b] : 0;
    for (int a = 0; a < TR-1; a++)
      for (int b = 0; b < TC-1; b++)
        cs[a][b] = tt[a][b] + tt[a][b+1] + tt[a+1][b] + tt[a+1][b+1];
    exp_hit = '0; exp_e = '0; exp_v = '0;
    for (int i = 0; i < OR; i++)
      for (int j = 0; j < OC; j++) begin
        r = i + 1; c = j + 1; k = i*OC + j; s = cs[r][c];
        win = s > cs[r-1][c] && s > cs[r][c-1] && s > cs[r-1][c-1] && s > cs[r-1][c+1]
           && s >= cs[r+1][c] && s >= cs[r][c+1] && s >= cs[r+1][c+1] && s >= cs[r+1][c-1];
        if (win && s >= int'(clus_thr)) begin
          exp_hit[k] = 1'b1;
          exp_e[k*SW +: SW] = SW'(s);
        end
        exp_v[k] = tv[r][c] | tv[r][c+1] | tv[r+1][c] | tv[r+1][c+1];
      end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    model();
    chk({tag, " hit"}, 128'(clus_hit), 128'(exp_hit));
    chk({tag, " energy"}, 128'(clus_e), 128'(exp_e));
    chk({tag, " veto"}, 128'(clus_veto), 128'(exp_v));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] l;
    clear_grid();
    te[2][2] = 300; tv[2][2] = 1;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 outputs held at zero in reset
    chk("R9 reset hit", 128'(clus_hit), 128'(0));
    chk("R9 reset energy", 128'(clus_e), 128'(0));
    chk("R9 reset veto", 128'(clus_veto), 128'(0));
    rst_n = 1;
    settle();
    check_all("R2/R3 after reset");

    // Table of random grids under several thresholds (R1 R2 R3 R5 R6 R7)
    for (int n = 0; n < 6; n++) begin
      l = VT[n].seed;
      for (int r = 0; r < TR; r++)
        for (int c = 0; c < TC; c++) begin
          l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
          te[r][c] = int'(l[8:0] & VT[n].emask);
          tv[r][c] = l[15] & l[3];
        end
      tower_thr = VT[n].tthr;
      clus_thr  = VT[n].cthr;
      drive();
      settle();
      check_all($sformatf("R1/R3/R5/R7 table %0d", n));
    end

    // R4 single tower: four equal clusters, only the up-left one survives
    tower_thr = '0; clus_thr = '0;
    clear_grid(); te[2][2] = 100; drive(); settle();
    chk("R4 equal four hit", 128'(clus_hit), 128'(9'b000000001));
    chk("R6 equal four energy", 128'(clus_e), 128'(99'd100));

    // R4 horizontal tie between two 200 clusters
    clear_grid(); te[2][3] = 100; te[3][3] = 100; drive(); settle();
    chk("R4 pair tie hit", 128'(clus_hit), 128'(9'b000010000));
    chk("R4 pair tie energy", 128'(clus_e[4*SW +: SW]), 128'(200));

    // R1 below threshold, R7 veto still reported
    tower_thr = 9'd60;
    clear_grid(); te[2][2] = 59; tv[2][2] = 1; drive(); settle();
    chk("R1 below thr hit", 128'(clus_hit), 128'(0));
    chk("R7 veto unaffected", 128'(clus_veto), 128'(9'b000011011));
    // R1 equal to threshold is kept
    te[2][2] = 60; drive(); settle();
    chk("R1 at thr hit", 128'(clus_hit), 128'(9'b000000001));
    chk("R1 at thr energy", 128'(clus_e[0 +: SW]), 128'(60));
    tower_thr = '0;

    // R5 prune boundary
    clear_grid(); te[2][2] = 100; clus_thr = 11'd101; drive(); settle();
    chk("R5 below cluster thr", 128'(clus_hit), 128'(0));
    chk("R6 pruned energy zero", 128'(clus_e), 128'(0));
    clus_thr = 11'd100; settle();
    chk("R5 at cluster thr", 128'(clus_hit), 128'(9'b000000001));
    clus_thr = '0;

    // R10 border cluster suppresses interior
    clear_grid(); te[1][1] = 200; drive(); settle();
    chk("R10 border wins", 128'(clus_hit), 128'(0));

    // R2 full-scale sum
    clear_grid(); te[2][2] = 511; te[2][3] = 511; te[3][2] = 511; te[3][3] = 511;
    drive(); settle();
    chk("R2 full scale hit", 128'(clus_hit), 128'(9'b000010000));
    chk("R2 full scale energy", 128'(clus_e[4*SW +: SW]), 128'(2044));

    // R8 latency: old result persists after two edges, new after three
    clear_grid(); te[2][2] = 100; drive(); settle();
    clear_grid(); te[3][3] = 77; drive();
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8 two edges old", 128'(clus_hit), 128'(9'b000000001));
    @(posedge clk); @(negedge clk);
    chk("R8 three edges new", 128'(clus_hit), 128'(9'b000010000));
    chk("R8 three edges energy", 128'(clus_e[4*SW +: SW]), 128'(77));

    // R9 asynchronous clear
    #2 rst_n = 0;
    #1;
    chk("R9 async clear", 128'(clus_hit), 128'(0));
    @(negedge clk); rst_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule